// File: doc/BRIEF.md
# SPI Target Serial Front End with Clock-Mode Detection

This block is the serial edge of a small memory-style SPI target. It oversamples the serial pins (SCK, chip select, serial input and an external active-low reset) on a fast system clock. It works out the SPI clock mode each time chip select falls. It assembles incoming bytes most significant bit first and hands each byte to the command logic as a one-cycle strobe. It shifts a byte supplied by that logic out on the serial output. An output enable tells the pad when SO is driven; when the enable is low, the pad is in high impedance.

The block also turns a busy request from a self-timed operation engine into an active-low busy status pin. It guards accesses made while that engine runs. The main array and the buffer that the engine is using (a 1-bit index) are refused and flagged as errors. The other buffer stays usable.

The external reset input aborts any frame in progress and tells the engine to stop, through `op_abort`. The block then waits for a fresh chip-select fall before it accepts a new instruction. A power-on reset (`por_n`) puts the block in the same idle state.

All serial pins pass through a two-stage synchroniser followed by an edge detector. A pin change that is captured at clock edge k therefore takes effect on the registered outputs at edge k+2.

Top module: `spi_target_fe`

## Requirements
- R1: While the synchronised `reset_in_n` is low, the block holds the frame idle. `so_oe` stays low, no `rx_valid` strobe is produced, `busy_n` is high even if `op_busy` is high, and `op_abort` is high.
- R2: After power-on or after `reset_in_n` returns high, `mode3` reads 1 and `so_oe` reads 0. A frame starts only on a high-to-low transition of `cs_n` that follows `cs_n` being seen high. With `cs_n` already low when reset ends, SCK activity produces no byte.
- R3: At each frame-starting fall of `cs_n`, the SCK level is sampled. High sets `mode3`=1 (mode 3) and low sets `mode3`=0 (mode 0). The value holds until the next frame start or reset.
- R4: Within a frame, `si` is sampled on each SCK rising edge, most significant bit first. After the 8th rising edge, `rx_valid` pulses for exactly one cycle with the assembled byte on `rx_byte`.
- R5: `so` carries bit 7 of the output shift register. At frame start and on the first SCK falling edge after each completed byte, `tx_byte` is loaded. Every other SCK falling edge shifts the register left. The first bit is therefore valid before the first SCK rising edge in both modes.
- R6: `so_oe` is 1 exactly while a frame is open and `out_phase` is 1. When `so_oe` is 0, `so` reads 0.
- R7: Raising `cs_n` in the middle of a byte closes the frame and discards the partial bits without an `rx_valid` strobe. The next frame assembles its first byte from scratch.
- R8: `busy_n` is the registered inverse of `op_busy`: low one cycle after `op_busy` is high, and high otherwise.
- R9: For an access request (`acc_req`=1), exactly one of `acc_ok` or `acc_err` pulses one cycle later. `acc_err` is chosen when the engine is busy and the access targets the array (`acc_array`=1) or the buffer whose index (`acc_buf`) equals the `op_buf` value captured when busy began. `acc_ok` is chosen otherwise. No result is produced during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| reset_in_n | input | 1 | External reset pin, active low |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Chip select pin, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out (0 when not enabled) |
| so_oe | output | 1 | Output enable for the SO pad |
| busy_n | output | 1 | Busy status, active low |
| rx_valid | output | 1 | One-cycle strobe: byte received |
| rx_byte | output | 8 | Received byte |
| tx_byte | input | 8 | Byte to send next |
| out_phase | input | 1 | Current instruction has an output phase |
| mode3 | output | 1 | 1 = mode 3 detected, 0 = mode 0 |
| op_busy | input | 1 | Busy request from the timed-operation engine |
| op_buf | input | 1 | Buffer index used by the busy operation |
| op_abort | output | 1 | Tells the engine to stop (reset active) |
| acc_req | input | 1 | Access request from the command logic |
| acc_array | input | 1 | Access targets the main array |
| acc_buf | input | 1 | Buffer index of the access |
| acc_ok | output | 1 | Access accepted (pulse) |
| acc_err | output | 1 | Access refused (pulse) |

## Verification
On every cycle, the assertions check the following:
- the frame collapses to idle under reset and on a chip-select rise;
- the detected mode equals the SCK level at the frame-starting edge;
- strobes never last two cycles;
- busy status follows the engine request;
- an array access during busy is flagged;
- the enable drops once chip select is high.

Some behaviour can only be shown by the bench scenarios, because it depends on whole sequences:
- correct byte assembly and output order in both modes;
- the need for a fresh chip-select fall after reset;
- the loss of a partial byte;
- that the buffer not in use stays open while the engine runs.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NPIN   = 4;

    // decoded pin events, one clock after the synchronised level changes
    typedef struct packed {
        logic cs_fall;
        logic cs_high;
        logic sck_rise;
        logic sck_fall;
        logic sck_lvl;
        logic si_lvl;
        logic clr;
    } pin_ev_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_fe_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic [NPIN-1:0] pins_i,   // {reset_in_n, si, sck, cs_n}
    output pin_ev_t         ev_o
);
    // idle levels: cs high, sck high (mode 3), si low, reset asserted
    localparam logic [NPIN-1:0] RST_VAL = 4'b0011;

    logic [NPIN-1:0] cur;
    logic [NPIN-1:0] prv;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [STAGES:0] ch_d, ch_q;
        always_comb ch_d = {ch_q[STAGES-1:0], pins_i[g]};
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) ch_q <= {(STAGES+1){RST_VAL[g]}};
            else        ch_q <= ch_d;
        end
        assign cur[g] = ch_q[STAGES-1];
        assign prv[g] = ch_q[STAGES];
    end

    always_comb begin
        ev_o.cs_fall  = !cur[0] && prv[0];
        ev_o.cs_high  = cur[0];
        ev_o.sck_rise = cur[1] && !prv[1];
        ev_o.sck_fall = !cur[1] && prv[1];
        ev_o.sck_lvl  = cur[1];
        ev_o.si_lvl   = cur[2];
        ev_o.clr      = !cur[3];
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_fe_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  pin_ev_t      ev,
    input  logic [W-1:0] tx_byte,
    output logic         active,
    output logic         mode3,
    output logic         tx_msb,
    output logic         rx_valid,
    output logic [W-1:0] rx_byte
);
    localparam int unsigned    CW   = $clog2(W);
    localparam logic [CW-1:0]  LAST = CW'(W - 1);

    typedef struct packed {
        logic          active;
        logic          armed;
        logic          mode3;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rx_sh;
        logic [W-1:0]  tx_sh;
        logic          rx_valid;
        logic [W-1:0]  rx_byte;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rx_valid = 1'b0;
        if (ev.clr) begin
            st_d.active = 1'b0;
            st_d.armed  = 1'b0;
            st_d.cnt    = '0;
            st_d.mode3  = 1'b1;
            st_d.tx_sh  = '0;
        end else begin
            if (st_q.active) begin
                if (ev.cs_high) begin
                    st_d.active = 1'b0;
                    st_d.cnt    = '0;
                end else if (ev.sck_rise) begin
                    st_d.rx_sh = {st_q.rx_sh[W-2:0], ev.si_lvl};
                    if (st_q.cnt == LAST) begin
                        st_d.rx_valid = 1'b1;
                        st_d.rx_byte  = {st_q.rx_sh[W-2:0], ev.si_lvl};
                        st_d.cnt      = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CW'(1);
                    end
                end else if (ev.sck_fall) begin
                    st_d.tx_sh = (st_q.cnt == '0) ? tx_byte
                                                  : {st_q.tx_sh[W-2:0], 1'b0};
                end
            end else if (ev.cs_fall && st_q.armed) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                st_d.mode3  = ev.sck_lvl;
                st_d.tx_sh  = tx_byte;
                st_d.rx_sh  = '0;
            end
            if (ev.cs_high) st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q       <= '0;
            st_q.mode3 <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active   = st_q.active;
    assign mode3    = st_q.mode3;
    assign tx_msb   = st_q.tx_sh[W-1];
    assign rx_valid = st_q.rx_valid;
    assign rx_byte  = st_q.rx_byte;

    p_idle_in_reset_r1: assert property (@(posedge clk) disable iff (!por_n)
        ev.clr |=> (!st_q.active && !st_q.rx_valid));

    p_mode_pick_r3: assert property (@(posedge clk) disable iff (!por_n)
        (!ev.clr && !st_q.active && ev.cs_fall && st_q.armed)
            |=> (st_q.mode3 == $past(ev.sck_lvl)));

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!por_n)
        st_q.rx_valid |=> !st_q.rx_valid);

    p_abort_frame_r7: assert property (@(posedge clk) disable iff (!por_n)
        (!ev.clr && st_q.active && ev.cs_high)
            |=> (!st_q.active && !st_q.rx_valid));
endmodule

// File: rtl/busy_guard.sv
module busy_guard (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic op_busy,
    input  logic op_buf,
    input  logic acc_req,
    input  logic acc_array,
    input  logic acc_buf,
    output logic busy_n,
    output logic acc_ok,
    output logic acc_err
);
    typedef struct packed {
        logic busy;
        logic buf_sel;
        logic ok;
        logic err;
    } guard_st_t;

    guard_st_t gd_d, gd_q;
    logic      blocked;

    always_comb begin
        gd_d     = gd_q;
        gd_d.ok  = 1'b0;
        gd_d.err = 1'b0;
        blocked  = gd_q.busy && (acc_array || (acc_buf == gd_q.buf_sel));
        if (!clr && acc_req) begin
            gd_d.err = blocked;
            gd_d.ok  = !blocked;
        end
        if (!gd_q.busy) gd_d.buf_sel = op_buf;
        gd_d.busy = clr ? 1'b0 : op_busy;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) gd_q <= '0;
        else        gd_q <= gd_d;
    end

    assign busy_n  = !gd_q.busy;
    assign acc_ok  = gd_q.ok;
    assign acc_err = gd_q.err;

    p_busy_follow_r8: assert property (@(posedge clk) disable iff (!por_n)
        (!clr && op_busy) |=> !busy_n);

    p_busy_release_r1: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> busy_n);

    p_array_blocked_r9: assert property (@(posedge clk) disable iff (!por_n)
        (!clr && acc_req && !busy_n && acc_array) |=> (acc_err && !acc_ok));

    p_one_result_r9: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({acc_ok, acc_err}));
endmodule

// File: rtl/spi_target_fe.sv
module spi_target_fe
    import spi_fe_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              reset_in_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic              busy_n,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              out_phase,
    output logic              mode3,
    input  logic              op_busy,
    input  logic              op_buf,
    output logic              op_abort,
    input  logic              acc_req,
    input  logic              acc_array,
    input  logic              acc_buf,
    output logic              acc_ok,
    output logic              acc_err
);
    pin_ev_t ev;
    logic    frame_open;
    logic    tx_msb;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .por_n  (por_n),
        .pins_i ({reset_in_n, si, sck, cs_n}),
        .ev_o   (ev)
    );

    spi_shift_core #(.W(BYTE_W)) u_core (
        .clk      (clk),
        .por_n    (por_n),
        .ev       (ev),
        .tx_byte  (tx_byte),
        .active   (frame_open),
        .mode3    (mode3),
        .tx_msb   (tx_msb),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    busy_guard u_guard (
        .clk       (clk),
        .por_n     (por_n),
        .clr       (ev.clr),
        .op_busy   (op_busy),
        .op_buf    (op_buf),
        .acc_req   (acc_req),
        .acc_array (acc_array),
        .acc_buf   (acc_buf),
        .busy_n    (busy_n),
        .acc_ok    (acc_ok),
        .acc_err   (acc_err)
    );

    assign so_oe    = frame_open && out_phase;
    assign so       = so_oe && tx_msb;
    assign op_abort = ev.clr;

    p_oe_drop_r6: assert property (@(posedge clk) disable iff (!por_n)
        ev.cs_high |=> !so_oe);
endmodule

// File: tb/tb_spi_target_fe.sv
`timescale 1ns/100ps
module tb_spi_target_fe;
    localparam int H = 6;  // SCK half period in clk cycles

    logic clk = 0, por_n = 0, reset_in_n = 1, sck = 1, cs_n = 1, si = 0;
    logic [7:0] tx_byte = 8'h00;
    logic out_phase = 0, op_busy = 0, op_buf = 0;
    logic acc_req = 0, acc_array = 0, acc_buf = 0;
    logic so, so_oe, busy_n, rx_valid, mode3, op_abort, acc_ok, acc_err;
    logic [7:0] rx_byte;

    int errs = 0, nchk = 0, cyc = 0;
    bit done = 0;
    logic [7:0] rxq[$];

    always #2 clk = ~clk;  // 250 MHz

    spi_target_fe dut (.clk(clk), .por_n(por_n), .reset_in_n(reset_in_n), .sck(sck),
        .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe), .busy_n(busy_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte), .out_phase(out_phase),
        .mode3(mode3), .op_busy(op_busy), .op_buf(op_buf), .op_abort(op_abort),
        .acc_req(acc_req), .acc_array(acc_array), .acc_buf(acc_buf),
        .acc_ok(acc_ok), .acc_err(acc_err));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit mc1, mc2, mc3, ms1, ms2, ms3, mi1, mi2, mr1, mr2;
    bit m_act, m_arm, m_mode, m_val, m_busy, m_sel, m_ok, m_err;
    int m_cnt;
    logic [7:0] m_rx, m_tx, m_byte;

    always @(posedge clk) begin
        if (!por_n) begin
            mc1 = 1; mc2 = 1; mc3 = 1; ms1 = 1; ms2 = 1; ms3 = 1;
            mi1 = 0; mi2 = 0; mr1 = 0; mr2 = 0;
            m_act = 0; m_arm = 0; m_mode = 1; m_val = 0; m_cnt = 0;
            m_rx = 0; m_tx = 0; m_byte = 0; m_busy = 0; m_sel = 0; m_ok = 0; m_err = 0;
        end else begin
            bit clr, blk;
            clr = !mr2;
            m_ok = 0; m_err = 0;
            if (!clr && acc_req) begin
                blk = m_busy && (acc_array || acc_buf == m_sel);
                m_err = blk; m_ok = !blk;
            end
            if (!m_busy) m_sel = op_buf;
            m_busy = clr ? 0 : op_busy;
            m_val = 0;
            if (clr) begin
                m_act = 0; m_arm = 0; m_cnt = 0; m_mode = 1; m_tx = 0;
            end else begin
                if (m_act) begin
                    if (mc2) begin m_act = 0; m_cnt = 0; end
                    else if (ms2 && !ms3) begin
                        m_rx = {m_rx[6:0], mi2};
                        if (m_cnt == 7) begin m_val = 1; m_byte = m_rx; m_cnt = 0; end
                        else m_cnt++;
                    end else if (!ms2 && ms3)
                        m_tx = (m_cnt == 0) ? tx_byte : {m_tx[6:0], 1'b0};
                end else if (!mc2 && mc3 && m_arm) begin
                    m_act = 1; m_cnt = 0; m_mode = ms2; m_tx = tx_byte; m_rx = 0;
                end
                if (mc2) m_arm = 1;
            end
            mc3 = mc2; mc2 = mc1; mc1 = cs_n;
            ms3 = ms2; ms2 = ms1; ms1 = sck;
            mi2 = mi1; mi1 = si;
            mr2 = mr1; mr1 = reset_in_n;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (por_n && !done) begin
            bit eoe;
            eoe = m_act && out_phase;
            chk(so_oe == eoe, "R6 so_oe", so_oe, eoe);
            chk(so == (eoe && m_tx[7]), "R5 so", so, eoe && m_tx[7]);
            chk(mode3 == m_mode, "R3 mode3", mode3, m_mode);
            chk(rx_valid == m_val, "R4 rx_valid", rx_valid, m_val);
            if (m_val) chk(rx_byte == m_byte, "R4 rx_byte", rx_byte, m_byte);
            chk(busy_n == !m_busy, "R8 busy_n", busy_n, !m_busy);
            chk(acc_ok == m_ok && acc_err == m_err, "R9 acc result",
                {acc_ok, acc_err}, {m_ok, m_err});
            if (rx_valid) rxq.push_back(rx_byte);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic frame_open(input bit idle_hi);
        sck = idle_hi; wcyc(4);
        cs_n = 0; wcyc(4);
    endtask

    task automatic frame_close();
        sck = mode3; wcyc(H);
        cs_n = 1; wcyc(6);
    endtask

    task automatic xfer(input logic [7:0] din, input logic [7:0] tnext, input int nbits,
                        output logic [7:0] got);
        tx_byte = tnext;
        got = 0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sck = 0; si = din[i]; wcyc(H);
            got[i] = so;
            sck = 1; wcyc(H);
        end
    endtask

    task automatic access(input bit arr, input bit bsel, input bit exp_err, input string tag);
        acc_req = 1; acc_array = arr; acc_buf = bsel;
        wcyc(1);
        acc_req = 0;
        chk(acc_err == exp_err && acc_ok == !exp_err, tag, {acc_ok, acc_err}, {!exp_err, exp_err});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errs++; nchk++;
            $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] g;
        wcyc(5);
        por_n = 1;
        wcyc(8);
        // R2: start-up state
        chk(mode3 == 1, "R2 mode3 after power-on", mode3, 1);
        chk(so_oe == 0, "R2 so_oe after power-on", so_oe, 0);
        chk(busy_n == 1, "R8 busy_n idle", busy_n, 1);

        // mode 3 frame, two bytes, output phase on
        out_phase = 1; tx_byte = 8'hA5;
        frame_open(1);
        chk(mode3 == 1, "R3 mode 3 detected", mode3, 1);
        chk(so_oe == 1, "R6 so_oe in output frame", so_oe, 1);
        xfer(8'h3C, 8'hA5, 8, g);
        chk(g == 8'hA5, "R5 mode 3 first byte out", g, 8'hA5);
        xfer(8'hC3, 8'h5A, 8, g);
        chk(g == 8'h5A, "R5 mode 3 second byte out", g, 8'h5A);
        frame_close();
        chk(rxq.size() == 2 && rxq[0] == 8'h3C && rxq[1] == 8'hC3, "R4 mode 3 bytes in",
            rxq.size() > 0 ? rxq[0] : 0, 8'h3C);
        rxq.delete();

        // mode 0 frame, no output phase
        out_phase = 0;
        frame_open(0);
        chk(mode3 == 0, "R3 mode 0 detected", mode3, 0);
        chk(so_oe == 0, "R6 so_oe off without output phase", so_oe, 0);
        xfer(8'h81, 8'h00, 8, g);
        frame_close();
        chk(rxq.size() == 1 && rxq[0] == 8'h81, "R4 mode 0 byte in",
            rxq.size() > 0 ? rxq[0] : 0, 8'h81);
        rxq.delete();

        // mode 0 with output
        out_phase = 1; tx_byte = 8'h96;
        frame_open(0);
        xfer(8'h00, 8'h96, 8, g);
        chk(g == 8'h96, "R5 mode 0 byte out", g, 8'h96);
        frame_close();
        chk(so_oe == 0, "R6 so_oe after cs high", so_oe, 0);
        rxq.delete();

        // R7: partial byte discarded
        frame_open(0);
        xfer(8'hFF, 8'h00, 3, g);
        cs_n = 1; wcyc(8);
        chk(rxq.size() == 0, "R7 no strobe on partial byte", rxq.size(), 0);
        frame_open(0);
        xfer(8'h7E, 8'h00, 8, g);
        frame_close();
        chk(rxq.size() == 1 && rxq[0] == 8'h7E, "R7 next byte fresh",
            rxq.size() > 0 ? rxq[0] : 0, 8'h7E);
        rxq.delete();

        // R1: reset in mid frame
        frame_open(1);
        xfer(8'hF0, 8'h00, 4, g);
        reset_in_n = 0; op_busy = 1;
        wcyc(6);
        chk(so_oe == 0, "R1 so_oe in reset", so_oe, 0);
        chk(busy_n == 1, "R1 busy_n released in reset", busy_n, 1);
        chk(op_abort == 1, "R1 op_abort in reset", op_abort, 1);
        xfer(8'hF0, 8'h00, 8, g);
        chk(rxq.size() == 0, "R1 no byte while reset", rxq.size(), 0);
        op_busy = 0;
        // R2: cs still low when reset ends
        reset_in_n = 1; wcyc(6);
        chk(mode3 == 1, "R2 mode3 after reset", mode3, 1);
        xfer(8'h55, 8'h00, 8, g);
        wcyc(6);
        chk(rxq.size() == 0 && so_oe == 0, "R2 no frame without cs fall", rxq.size(), 0);
        cs_n = 1; wcyc(6);
        frame_open(0);
        xfer(8'h11, 8'h00, 8, g);
        frame_close();
        chk(rxq.size() == 1 && rxq[0] == 8'h11, "R2 frame after fresh cs fall",
            rxq.size() > 0 ? rxq[0] : 0, 8'h11);
        rxq.delete();

        // R8/R9: busy and buffer guard
        op_buf = 0; op_busy = 1; wcyc(3);
        chk(busy_n == 0, "R8 busy_n low while busy", busy_n, 0);
        op_buf = 1; // index change after start must not move the block
        access(0, 1, 0, "R9 other buffer allowed");
        access(0, 0, 1, "R9 busy buffer refused");
        access(1, 0, 1, "R9 array refused");
        op_busy = 0; wcyc(3);
        chk(busy_n == 1, "R8 busy_n released", busy_n, 1);
        access(0, 0, 0, "R9 buffer allowed when idle");
        access(1, 1, 0, "R9 array allowed when idle");
        wcyc(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule